// File: doc/BRIEF.md
# DRAM Command Expander

This block sits in the per-rank slice of a near-memory processing unit. It takes one compact instruction that describes a single embedding-vector fetch and turns it into the ordinary DRAM command stream for that fetch. The instruction carries three need flags (precharge, activate, read), a burst count in 64-byte units and a bank/row/column address. The block issues the commands one per slot on a command/address output qualified by a valid strobe. It keeps the read column stepping by 8 per burst and inserts idle slots so that the precharge-to-activate, activate-to-read and read-to-read minimum spacings are met.

The host controller has already decided row-buffer state, ordering, arbitration and refresh. The expander trusts the flags as given and does no bank-state inference of its own. It takes one instruction at a time and reports `busy` to the instruction source until the last command of the current fetch has gone out. An instruction with all flags cleared but a nonzero burst count is a row hit and issues reads only.

Top module: `dram_cmd_expander`

## Requirements
- R1: Reset is synchronous and active low. After a reset edge `busy` is 0, `cmd_valid` is 0 and `cmd_op` is NOP (0). The spacing history is cleared, so the first command after reset is not held back by commands issued before it.
- R2: An instruction is taken on a rising edge where `ins_valid` is 1 and `busy` is 0. Flag bit `ins_need[0]` requests PRE, `ins_need[1]` requests ACT and `ins_need[2]` requests RD, with 1 meaning required. Commands go out in the order PRE, ACT, then reads. The first command is placed on the output at the edge after the accepting edge.
- R3: `cmd_op` codes are NOP=0, ACT=1, RD=2 and PRE=3. `cmd_valid` is high for exactly one cycle per command, and `cmd_op` is NOP while it is low. ACT drives the row on `cmd_addr`, RD drives the column zero-extended, and PRE drives 0. Every command carries the instruction's bank on `cmd_bank`.
- R4: With the RD flag set, the instruction issues `ins_bursts` reads. Read k (counting from 0) uses column `ins_col + 8*k` modulo 2^COL_W.
- R5: An instruction with all three flags clear and a nonzero `ins_bursts` is a row hit and issues only its `ins_bursts` reads.
- R6: With the RD flag clear and at least one other flag set, no read is issued whatever `ins_bursts` holds. An instruction that requests no command at all is consumed without any output and without raising `busy`.
- R7: ACT comes at least T_RP edges after the last PRE, and RD at least T_RCD edges after the last ACT. RD comes at least T_CCD edges after the previous RD, including one issued by an earlier instruction. Each command issues at the earliest edge that meets all of these spacings.
- R8: `busy` rises at the accepting edge of an instruction that issues commands and falls at the edge that issues its last command. `ins_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Instruction offered |
| ins_need | input | 3 | Need flags: bit0 PRE, bit1 ACT, bit2 RD |
| ins_bursts | input | BURST_W | Number of 64-byte bursts (reads) |
| ins_bank | input | BANK_W | Target bank |
| ins_row | input | ROW_W | Row for ACT |
| ins_col | input | COL_W | Column of the first read |
| busy | output | 1 | Expansion in progress, new instructions ignored |
| cmd_valid | output | 1 | A command is on the output this cycle |
| cmd_op | output | 2 | Command code: 0 NOP, 1 ACT, 2 RD, 3 PRE |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row (ACT), column (RD) or 0 (PRE) |

## Verification
The interesting coincidence is the release of `busy` at the edge that issues the last read of one fetch, followed by the acceptance of the next instruction one cycle later. The new instruction's first read then collides with the read-to-read spacing left over from the previous fetch. The bench offers its vectors back to back at the first idle negative edge. A reference model built from the spacing rules predicts the exact issue cycle of every command, so a read issued too early, or a spacing window dropped across the instruction boundary, shows up as a wrong issue cycle. A second case offers a different instruction while `busy` is high and then confirms that only the original command stream appears.

// File: rtl/cexp_pkg.sv
// Package: shared encodings for the DRAM command expander.
// Assumes: 2-bit command code on the output, 3 need flags in fixed positions.
package cexp_pkg;

    // Command code placed on cmd_op.
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_PRE = 2'd3
    } dram_cmd_e;

    // Issue phase of the sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_ACT  = 2'd2,
        PH_RD   = 2'd3
    } phase_e;

    // Bit positions of the need flags in the instruction.
    localparam int NEED_PRE = 0;
    localparam int NEED_ACT = 1;
    localparam int NEED_RD  = 2;

endpackage

// File: rtl/cexp_operand.sv
// Module: cexp_operand
// Decodes the incoming instruction and holds its operands for the
// duration of the expansion. Steps the read column by COL_STEP and counts
// down the remaining reads on each read issue.
// Assumes: accept and rd_issue are never high in the same cycle.
module cexp_operand #(
    parameter int BANK_W   = 4,
    parameter int ROW_W    = 16,
    parameter int COL_W    = 10,
    parameter int BURST_W  = 3,
    parameter int COL_STEP = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         ins_need,
    input  logic [BURST_W-1:0] ins_bursts,
    input  logic [BANK_W-1:0]  ins_bank,
    input  logic [ROW_W-1:0]   ins_row,
    input  logic [COL_W-1:0]   ins_col,
    input  logic               accept,
    input  logic               rd_issue,
    output logic               dec_pre,
    output logic               dec_act,
    output logic [BURST_W-1:0] dec_rds,
    output logic               hold_act,
    output logic [BANK_W-1:0]  hold_bank,
    output logic [ROW_W-1:0]   hold_row,
    output logic [COL_W-1:0]   cur_col,
    output logic [BURST_W-1:0] rds_left
);
    import cexp_pkg::*;

    localparam logic [COL_W-1:0] STEP = COL_W'(COL_STEP);

    logic row_hit;

    // Decode: reads are issued when RD is flagged or when no flag is set.
    always_comb begin
        row_hit = (ins_need == 3'b000);
        dec_pre = ins_need[NEED_PRE];
        dec_act = ins_need[NEED_ACT];
        dec_rds = (ins_need[NEED_RD] || row_hit) ? ins_bursts : '0;
    end

    // Operand hold: load on accept, advance column and count on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_act  <= 1'b0;
            hold_bank <= '0;
            hold_row  <= '0;
            cur_col   <= '0;
            rds_left  <= '0;
        end else if (accept) begin
            hold_act  <= dec_act;
            hold_bank <= ins_bank;
            hold_row  <= ins_row;
            cur_col   <= ins_col;
            rds_left  <= dec_rds;
        end else if (rd_issue) begin
            cur_col   <= cur_col + STEP;
            rds_left  <= rds_left - 1'b1;
        end
    end

endmodule

// File: rtl/cexp_spacing.sv
// Module: cexp_spacing
// Tracks the edges elapsed since the last PRE, ACT and RD and reports
// whether an ACT or a RD may issue now. One saturating counter per rule,
// built by a generate loop over the rule table.
// Assumes: all spacing parameters are at least 1.
module cexp_spacing #(
    parameter int T_RP  = 16,
    parameter int T_RCD = 16,
    parameter int T_CCD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic iss_pre,
    input  logic iss_act,
    input  logic iss_rd,
    output logic ok_act,
    output logic ok_rd
);
    localparam int N_RULE = 3;
    localparam int T_MAX  = (T_RP > T_RCD) ? ((T_RP > T_CCD) ? T_RP : T_CCD)
                                            : ((T_RCD > T_CCD) ? T_RCD : T_CCD);
    localparam int CW     = $clog2(T_MAX + 1);
    localparam logic [CW-1:0] SAT = CW'(T_MAX);
    localparam int LIM [N_RULE] = '{T_RP, T_RCD, T_CCD};

    logic [N_RULE-1:0] restart;
    logic [N_RULE-1:0] met;

    // Rule order: 0 = PRE->ACT, 1 = ACT->RD, 2 = RD->RD.
    assign restart = {iss_rd, iss_act, iss_pre};

    generate
        for (genvar g = 0; g < N_RULE; g++) begin : g_rule
            logic [CW-1:0] cnt;

            // Edge counter since the rule's opening command, saturating.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= SAT;
                end else if (restart[g]) begin
                    cnt <= '0;
                end else if (cnt != SAT) begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign met[g] = (int'(cnt) + 1 >= LIM[g]);
        end
    endgenerate

    assign ok_act = met[0];
    assign ok_rd  = met[1] & met[2];

endmodule

// File: rtl/cexp_sequencer.sv
// Module: cexp_sequencer
// Walks an accepted instruction through its PRE, ACT and RD phases,
// holding each phase until its spacing is met, and drives busy.
// Assumes: operand hold reflects the instruction taken on accept.
module cexp_sequencer #(
    parameter int BURST_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic               dec_pre,
    input  logic               dec_act,
    input  logic [BURST_W-1:0] dec_rds,
    input  logic               hold_act,
    input  logic [BURST_W-1:0] rds_left,
    input  logic               ok_act,
    input  logic               ok_rd,
    output logic               accept,
    output logic               busy,
    output logic               iss_pre,
    output logic               iss_act,
    output logic               iss_rd
);
    import cexp_pkg::*;

    phase_e phase_q;
    phase_e phase_d;

    // Issue strobes and the next phase.
    always_comb begin
        accept  = ins_valid && (phase_q == PH_IDLE);
        iss_pre = (phase_q == PH_PRE);
        iss_act = (phase_q == PH_ACT) && ok_act;
        iss_rd  = (phase_q == PH_RD) && ok_rd;
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    if (dec_pre)             phase_d = PH_PRE;
                    else if (dec_act)        phase_d = PH_ACT;
                    else if (dec_rds != '0)  phase_d = PH_RD;
                    else                     phase_d = PH_IDLE;
                end
            end
            PH_PRE: begin
                if (hold_act)                phase_d = PH_ACT;
                else if (rds_left != '0)     phase_d = PH_RD;
                else                         phase_d = PH_IDLE;
            end
            PH_ACT: begin
                if (ok_act) begin
                    phase_d = (rds_left != '0) ? PH_RD : PH_IDLE;
                end
            end
            PH_RD: begin
                if (ok_rd && (rds_left == BURST_W'(1))) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/cexp_cmd_drive.sv
// Module: cexp_cmd_drive
// Registers the command slot: code, bank and address for one cycle per
// issued command, NOP with zero fields otherwise.
// Assumes: at most one issue strobe is high in a cycle.
module cexp_cmd_drive #(
    parameter int BANK_W = 4,
    parameter int ROW_W  = 16,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_pre,
    input  logic              iss_act,
    input  logic              iss_rd,
    input  logic [BANK_W-1:0] hold_bank,
    input  logic [ROW_W-1:0]  hold_row,
    input  logic [COL_W-1:0]  cur_col,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr
);
    import cexp_pkg::*;

    dram_cmd_e op_q;

    // Command slot register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            op_q      <= CMD_NOP;
            cmd_bank  <= '0;
            cmd_addr  <= '0;
        end else begin
            cmd_valid <= iss_pre | iss_act | iss_rd;
            op_q      <= CMD_NOP;
            cmd_bank  <= '0;
            cmd_addr  <= '0;
            if (iss_pre) begin
                op_q     <= CMD_PRE;
                cmd_bank <= hold_bank;
            end else if (iss_act) begin
                op_q     <= CMD_ACT;
                cmd_bank <= hold_bank;
                cmd_addr <= ADDR_W'(hold_row);
            end else if (iss_rd) begin
                op_q     <= CMD_RD;
                cmd_bank <= hold_bank;
                cmd_addr <= ADDR_W'(cur_col);
            end
        end
    end

    assign cmd_op = op_q;

endmodule

// File: rtl/dram_cmd_expander.sv
// Module: dram_cmd_expander (top)
// Expands one compact vector-fetch instruction into PRE/ACT/RD commands
// with auto-incremented read columns and minimum command spacing.
// Assumes: the instruction source has resolved row state; flags are trusted.
module dram_cmd_expander #(
    parameter int BANK_W   = 4,
    parameter int ROW_W    = 16,
    parameter int COL_W    = 10,
    parameter int BURST_W  = 3,
    parameter int COL_STEP = 8,
    parameter int T_RP     = 16,
    parameter int T_RCD    = 16,
    parameter int T_CCD    = 4,
    localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic [2:0]         ins_need,
    input  logic [BURST_W-1:0] ins_bursts,
    input  logic [BANK_W-1:0]  ins_bank,
    input  logic [ROW_W-1:0]   ins_row,
    input  logic [COL_W-1:0]   ins_col,
    output logic               busy,
    output logic               cmd_valid,
    output logic [1:0]         cmd_op,
    output logic [BANK_W-1:0]  cmd_bank,
    output logic [ADDR_W-1:0]  cmd_addr
);
    logic               accept;
    logic               dec_pre, dec_act;
    logic [BURST_W-1:0] dec_rds;
    logic               hold_act;
    logic [BANK_W-1:0]  hold_bank;
    logic [ROW_W-1:0]   hold_row;
    logic [COL_W-1:0]   cur_col;
    logic [BURST_W-1:0] rds_left;
    logic               ok_act, ok_rd;
    logic               iss_pre, iss_act, iss_rd;

    cexp_operand #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .BURST_W(BURST_W), .COL_STEP(COL_STEP)
    ) operand_i (
        .clk(clk), .rst_n(rst_n),
        .ins_need(ins_need), .ins_bursts(ins_bursts), .ins_bank(ins_bank),
        .ins_row(ins_row), .ins_col(ins_col),
        .accept(accept), .rd_issue(iss_rd),
        .dec_pre(dec_pre), .dec_act(dec_act), .dec_rds(dec_rds),
        .hold_act(hold_act), .hold_bank(hold_bank), .hold_row(hold_row),
        .cur_col(cur_col), .rds_left(rds_left)
    );

    cexp_spacing #(
        .T_RP(T_RP), .T_RCD(T_RCD), .T_CCD(T_CCD)
    ) spacing_i (
        .clk(clk), .rst_n(rst_n),
        .iss_pre(iss_pre), .iss_act(iss_act), .iss_rd(iss_rd),
        .ok_act(ok_act), .ok_rd(ok_rd)
    );

    cexp_sequencer #(
        .BURST_W(BURST_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid),
        .dec_pre(dec_pre), .dec_act(dec_act), .dec_rds(dec_rds),
        .hold_act(hold_act), .rds_left(rds_left),
        .ok_act(ok_act), .ok_rd(ok_rd),
        .accept(accept), .busy(busy),
        .iss_pre(iss_pre), .iss_act(iss_act), .iss_rd(iss_rd)
    );

    cexp_cmd_drive #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) drive_i (
        .clk(clk), .rst_n(rst_n),
        .iss_pre(iss_pre), .iss_act(iss_act), .iss_rd(iss_rd),
        .hold_bank(hold_bank), .hold_row(hold_row), .cur_col(cur_col),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
    );

endmodule

// File: rtl/dram_cmd_expander_chk.sv
// Module: dram_cmd_expander_chk
// Property checker bound to the expander. Watches the command output and
// busy at the ports and measures command spacing with its own counters.
// Assumes: spacing parameters match those of the bound instance.
module dram_cmd_expander_chk #(
    parameter int BURST_W = 3,
    parameter int T_RP    = 16,
    parameter int T_RCD   = 16,
    parameter int T_CCD   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ins_valid,
    input logic [2:0]         ins_need,
    input logic [BURST_W-1:0] ins_bursts,
    input logic               busy,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op
);
    localparam int T_MAX = (T_RP > T_RCD) ? ((T_RP > T_CCD) ? T_RP : T_CCD)
                                           : ((T_RCD > T_CCD) ? T_RCD : T_CCD);
    localparam int CW    = $clog2(T_MAX + 1) + 1;
    localparam logic [CW-1:0] SAT = CW'(T_MAX);

    logic [CW-1:0] since_pre, since_act, since_rd;
    logic          seen_pre, seen_act, seen_rd;
    logic          has_cmd;

    assign seen_pre = cmd_valid && (cmd_op == 2'd3);
    assign seen_act = cmd_valid && (cmd_op == 2'd1);
    assign seen_rd  = cmd_valid && (cmd_op == 2'd2);
    assign has_cmd  = ins_need[0] | ins_need[1] |
                      ((ins_need[2] | (ins_need == 3'b000)) & (ins_bursts != '0));

    // Sample-edge distance since each observed command type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre <= SAT;
            since_act <= SAT;
            since_rd  <= SAT;
        end else begin
            since_pre <= seen_pre ? CW'(1) : ((since_pre != SAT) ? since_pre + 1'b1 : since_pre);
            since_act <= seen_act ? CW'(1) : ((since_act != SAT) ? since_act + 1'b1 : since_act);
            since_rd  <= seen_rd  ? CW'(1) : ((since_rd  != SAT) ? since_rd  + 1'b1 : since_rd);
        end
    end

    // R7: ACT never closer than T_RP to the last PRE.
    p_rp_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_act |-> (int'(since_pre) >= T_RP));

    // R7: RD never closer than T_RCD to the last ACT.
    p_rcd_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rd |-> (int'(since_act) >= T_RCD));

    // R7: RD never closer than T_CCD to the previous RD.
    p_ccd_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rd |-> (int'(since_rd) >= T_CCD));

    // R2: a PRE-flagged instruction shows PRE two samples after acceptance.
    p_first_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !busy && ins_need[0]) |=> ##1 (cmd_valid && cmd_op == 2'd3));

    // R8: accepting an instruction with commands raises busy.
    p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !busy && has_cmd) |=> busy);

    // R8: commands appear only as the tail of a busy period.
    p_cmd_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(busy));

    // R6: an instruction requesting nothing leaves busy low.
    p_empty_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !busy && !has_cmd) |=> !busy);

endmodule

bind dram_cmd_expander dram_cmd_expander_chk #(
    .BURST_W(BURST_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_CCD(T_CCD)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_need(ins_need),
    .ins_bursts(ins_bursts), .busy(busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op)
);

// File: tb/dram_cmd_expander_tb_top.sv
// Bench for dram_cmd_expander: table-driven back-to-back instructions
// checked against a spacing model, then directed reset and busy tests.
module dram_cmd_expander_tb_top;

    localparam int BW = 4, RW = 16, CLW = 10, SW = 3;
    localparam int TRP = 16, TRCD = 16, TCCD = 4;
    localparam int AW = 16;
    localparam int NV = 8;

    // Vector: need[43:41] bursts[40:38] bank[37:34] row[33:18] col[17:8] count[7:0]
    localparam logic [43:0] VEC [NV] = '{
        {3'b111, 3'd2, 4'd3,  16'h1234, 10'h010, 8'd4},
        {3'b000, 3'd3, 4'd1,  16'h0000, 10'h3F8, 8'd3},
        {3'b110, 3'd1, 4'd5,  16'hBEEF, 10'h020, 8'd2},
        {3'b001, 3'd0, 4'd2,  16'h0000, 10'h000, 8'd1},
        {3'b100, 3'd4, 4'd7,  16'h0000, 10'h000, 8'd4},
        {3'b011, 3'd2, 4'd8,  16'h00F0, 10'h100, 8'd2},
        {3'b111, 3'd7, 4'd15, 16'hFFFF, 10'h3E0, 8'd9},
        {3'b000, 3'd0, 4'd4,  16'h0000, 10'h000, 8'd0}
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           ins_valid;
    logic [2:0]     ins_need;
    logic [SW-1:0]  ins_bursts;
    logic [BW-1:0]  ins_bank;
    logic [RW-1:0]  ins_row;
    logic [CLW-1:0] ins_col;
    logic           busy;
    logic           cmd_valid;
    logic [1:0]     cmd_op;
    logic [BW-1:0]  cmd_bank;
    logic [AW-1:0]  cmd_addr;

    // 50 MHz clock: 20 ns period.
    always #10 clk = ~clk;

    dram_cmd_expander #(
        .BANK_W(BW), .ROW_W(RW), .COL_W(CLW), .BURST_W(SW),
        .COL_STEP(8), .T_RP(TRP), .T_RCD(TRCD), .T_CCD(TCCD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_need(ins_need),
        .ins_bursts(ins_bursts), .ins_bank(ins_bank), .ins_row(ins_row),
        .ins_col(ins_col), .busy(busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    int lp = -1000, la = -1000, lr = -1000;
    int acc;
    int e_t[32], e_op[32], e_bank[32], e_addr[32];
    int n_e;
    int o_t[32], o_op[32], o_bank[32], o_addr[32];
    int n_o;

    task automatic chk(input string tag, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic add_exp(input int t, input int op, input int bank, input int addr);
        if (n_e < 32) begin
            e_t[n_e] = t; e_op[n_e] = op; e_bank[n_e] = bank; e_addr[n_e] = addr;
        end
        n_e++;
    endtask

    // Reference model built from R2..R7: order, addresses, earliest issue.
    task automatic model(input logic [2:0] need, input int bursts, input int bank,
                         input int row, input int col);
        int t;
        int rds;
        n_e = 0;
        t = acc + 1;
        rds = (need[2] || need == 3'b000) ? bursts : 0;
        if (need[0]) begin add_exp(t, 3, bank, 0); lp = t; t++; end
        if (need[1]) begin
            if (t < lp + TRP) t = lp + TRP;
            add_exp(t, 1, bank, row); la = t; t++;
        end
        for (int k = 0; k < rds; k++) begin
            if (t < la + TRCD) t = la + TRCD;
            if (t < lr + TCCD) t = lr + TCCD;
            add_exp(t, 2, bank, (col + 8 * k) % 1024); lr = t; t++;
        end
    endtask

    task automatic grab();
        if (cmd_valid) begin
            if (n_o < 32) begin
                o_t[n_o] = cyc; o_op[n_o] = int'(cmd_op);
                o_bank[n_o] = int'(cmd_bank); o_addr[n_o] = int'(cmd_addr);
            end
            n_o++;
        end
    endtask

    // Offer one instruction at the first idle negedge; called at a negedge.
    task automatic launch(input logic [2:0] need, input int bursts, input int bank,
                          input int row, input int col);
        while (busy) @(negedge clk);
        ins_need = need; ins_bursts = SW'(bursts); ins_bank = BW'(bank);
        ins_row = RW'(row); ins_col = CLW'(col); ins_valid = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
        acc = cyc;
        n_o = 0;
        grab();
        model(need, bursts, bank, row, col);
        chk("R8", "busy after accepting edge", int'(busy), (n_e > 0) ? 1 : 0);
    endtask

    task automatic drain();
        int g;
        g = 0;
        do begin
            @(negedge clk);
            grab();
            g++;
        end while (busy && g < 400);
    endtask

    task automatic compare(input string tag, input int exp_cnt);
        chk(tag, "command count", n_o, exp_cnt);
        for (int i = 0; i < n_e && i < n_o && i < 32; i++) begin
            chk("R2", "command code/order", o_op[i], e_op[i]);
            chk("R3", "command bank", o_bank[i], e_bank[i]);
            chk("R4", "command address", o_addr[i], e_addr[i]);
            chk("R7", "issue cycle after accept", o_t[i] - acc, e_t[i] - acc);
        end
    endtask

    function automatic string vtag(input int v);
        case (v)
            0: return "R2";
            1: return "R5";
            2: return "R3";
            3: return "R6";
            4: return "R4";
            5: return "R6";
            6: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Main stimulus.
    initial begin
        rst_n = 1'b0; ins_valid = 1'b0; ins_need = '0; ins_bursts = '0;
        ins_bank = '0; ins_row = '0; ins_col = '0;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "cmd_valid in reset", int'(cmd_valid), 0);
        chk("R1", "cmd_op in reset", int'(cmd_op), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: instructions offered back to back.
        for (int v = 0; v < NV; v++) begin
            launch(VEC[v][43:41], int'(VEC[v][40:38]), int'(VEC[v][37:34]),
                   int'(VEC[v][33:18]), int'(VEC[v][17:8]));
            drain();
            compare(vtag(v), int'(VEC[v][7:0]));
        end

        // R8: an instruction offered while busy is ignored.
        launch(3'b111, 1, 6, 16'h0AAA, 10'h040);
        for (int k = 0; k < 5; k++) begin
            ins_need = 3'b000; ins_bursts = 3'd3; ins_bank = 4'd9;
            ins_col = 10'h100; ins_valid = 1'b1;
            @(negedge clk);
            grab();
        end
        ins_valid = 1'b0;
        drain();
        repeat (6) begin @(negedge clk); grab(); end
        compare("R8", 3);

        // R1: reset in the middle of an expansion, then history is cleared.
        launch(3'b111, 2, 1, 16'h0055, 10'h000);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "busy after mid-run reset", int'(busy), 0);
        chk("R1", "cmd_valid after mid-run reset", int'(cmd_valid), 0);
        rst_n = 1'b1;
        lp = -1000; la = -1000; lr = -1000;
        launch(3'b000, 2, 4, 0, 10'h080);
        drain();
        compare("R1", 2);
        chk("R1", "first read delay after reset", (n_o > 0) ? o_t[0] - acc : -1, 1);

        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #4000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule